// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timer

This block is a memory-mapped peripheral with two independent 16-bit down-counting timers. Both sit behind a single 32-bit register port. The port carries a select, a write strobe, an address and write data, and returns read data and a response code. Each timer has its own register bank. Bank 0 sits at offset 0x00 and bank 1 at 0x20. Each bank holds four word registers: a reload value, the live count, a control word and an interrupt acknowledge.

An enabled timer decrements once per prescaled tick. The prescaler divides the input clock by 1, 16 or 256. When a tick arrives while the count is zero, the counter takes the reload value instead of decrementing. In periodic mode this reload also raises the timer's interrupt flag. In free-running mode it raises nothing. The `irq` output is the OR of both flags. Software drops a flag by writing any value to that timer's acknowledge register. Read data and the response code are combinational from the address and the current state. Writes take effect on the rising clock edge while `bus_sel` and `bus_we` are high.

Top module: `dual_timer_top`

## Requirements
- R1: After synchronous reset, every register of both banks reads 0 and `irq` is 0.
- R2: Within a bank, the word offsets are: reload value at 0x0 (reads its low 16 bits, zero-extended), live count at 0x4 (read-only, a write returns OK and changes nothing), control at 0x8, acknowledge at 0xC (reads 0). Bank 1 is bank 0 plus 0x20.
- R3: The control word has enable in bit 7, mode in bit 6 (1 = periodic, 0 = free-running) and the prescale code in bits 3:2. Every other bit is ignored on write and reads as 0.
- R4: A reload-value write keeps the low 16 bits of the data and places them in the count on the same edge. This holds even while the timer runs and a tick coincides.
- R5: In free-running mode, each tick decrements a nonzero count. A tick at count zero reloads the count and does not raise the interrupt.
- R6: In periodic mode, a tick at count zero reloads the count and sets that timer's interrupt flag.
- R7: Any write to a timer's acknowledge register clears only that timer's flag. `irq` stays high while either flag is set.
- R8: The prescale code sets the tick spacing: code 0 gives 1 clock, code 1 gives 16, code 2 gives 256 and code 3 gives 1.
- R9: A control write restarts the prescaler, so the next decrement comes a full divisor period after the write's edge.
- R10: With enable 0, the count holds its value.
- R11: An access whose address has a nonzero bit 1 or bit 0 returns response 1 (misaligned) with read data 0 and changes no state.
- R12: An aligned access to a bank above 1, or to offset 0x10–0x1C inside a bank, returns response 2 (unmapped) with read data 0 and changes no state. Response 0 means OK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address relative to the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_resp | output | 2 | 0 OK, 1 misaligned, 2 unmapped |
| irq | output | 1 | OR of both timers' interrupt flags |

## Verification
The bench builds the block with its default parameters: two timers, a 16-bit count and an 8-bit address. An 8-bit address leaves six unused bank slots and the 0x10–0x1C hole inside each bank, so the unmapped path is reachable. The 256 divisor needs only a few hundred cycles at the 16-bit width, so the bench measures every divisor edge-exact. The same applies to the restart-on-control-write window and to the reload tick at zero. Both banks are driven against each other to show that acknowledge and prescaler state stay per timer.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DATA_W  = 32;
    localparam int PHASE_W = 8;
    localparam int BANK_SH = 5;

    typedef enum logic [1:0] {
        RSP_OK       = 2'b00,
        RSP_MISALIGN = 2'b01,
        RSP_UNMAPPED = 2'b10
    } bus_rsp_e;

    typedef enum logic [1:0] {
        PSC_DIV1   = 2'b00,
        PSC_DIV16  = 2'b01,
        PSC_DIV256 = 2'b10,
        PSC_RSVD   = 2'b11
    } psc_code_e;

    typedef enum logic [1:0] {
        SLOT_RELOAD = 2'b00,
        SLOT_COUNT  = 2'b01,
        SLOT_CTRL   = 2'b10,
        SLOT_ACK    = 2'b11
    } slot_e;

    typedef struct packed {
        logic      enable;
        logic      periodic;
        psc_code_e psc;
    } tmr_ctrl_t;

    // Terminal phase value for each prescale code; the reserved code behaves as divide-by-1.
    function automatic logic [PHASE_W-1:0] psc_limit(input psc_code_e code);
        case (code)
            PSC_DIV16:  psc_limit = 8'd15;
            PSC_DIV256: psc_limit = 8'd255;
            default:    psc_limit = 8'd0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input tmr_ctrl_t c);
        ctrl_to_word = {24'b0, c.enable, c.periodic, 2'b00, c.psc, 2'b00};
    endfunction

endpackage

// File: rtl/dtmr_decode.sv
module dtmr_decode
    import dtmr_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int ADDR_W   = 8,
    localparam int BANK_IW = ADDR_W - BANK_SH
) (
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    output bus_rsp_e            rsp,
    output logic [BANK_IW-1:0]  bank,
    output slot_e               slot,
    output logic [N_TIMERS-1:0] wr_reload,
    output logic [N_TIMERS-1:0] wr_ctrl,
    output logic [N_TIMERS-1:0] wr_ack
);

    logic misaligned;
    logic in_bank_hole;
    logic bank_present;
    logic hit;

    assign bank         = bus_addr[ADDR_W-1:BANK_SH];
    assign slot         = slot_e'(bus_addr[3:2]);
    assign misaligned   = (bus_addr[1:0] != 2'b00);
    assign in_bank_hole = (bus_addr[BANK_SH-1:4] != '0);
    assign bank_present = (32'(bank) < N_TIMERS);

    always_comb begin
        if (!bus_sel)                        rsp = RSP_OK;
        else if (misaligned)                 rsp = RSP_MISALIGN;
        else if (!bank_present || in_bank_hole) rsp = RSP_UNMAPPED;
        else                                 rsp = RSP_OK;
    end

    assign hit = bus_sel && bus_we && !misaligned && bank_present && !in_bank_hole;

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_strobe
        logic this_bank;
        assign this_bank    = hit && (bank == BANK_IW'(g));
        assign wr_reload[g] = this_bank && (slot == SLOT_RELOAD);
        assign wr_ctrl[g]   = this_bank && (slot == SLOT_CTRL);
        assign wr_ack[g]    = this_bank && (slot == SLOT_ACK);
    end

endmodule

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
    import dtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      restart,
    input  psc_code_e code,
    output logic      tick
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] limit;

    assign limit = psc_limit(code);
    // A restarting cycle never ticks, so the first decrement lands one full period later.
    assign tick  = enable && !restart && (phase_q == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) begin
            phase_q <= '0;
        end else if (phase_q == limit) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PHASE_W'(1);
        end
    end

    // R8: the phase never runs past the divisor chosen by the current code
    a_r8_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        phase_q <= psc_limit(code));

    // R9: the edge after a restart always starts counting from phase zero
    a_r9_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == '0));

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_reload,
    input  logic             wr_ctrl,
    input  logic             wr_ack,
    input  logic [CNT_W-1:0] wdata_cnt,
    input  tmr_ctrl_t        wdata_ctrl,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] count_o,
    output tmr_ctrl_t        ctrl_o,
    output logic             irq_o
);

    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             flag_q;
    logic             tick;
    logic             at_zero;
    logic             wrap_evt;
    logic             periodic_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{enable: 1'b0, periodic: 1'b0, psc: PSC_DIV1};
        end else if (wr_ctrl) begin
            ctrl_q <= wdata_ctrl;
        end
    end

    dtmr_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .enable  (ctrl_q.enable),
        .restart (wr_ctrl),
        .code    (ctrl_q.psc),
        .tick    (tick)
    );

    assign at_zero    = (count_q == '0);
    assign wrap_evt   = tick && at_zero && !wr_reload;
    assign periodic_w = ctrl_q.periodic;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            count_q  <= '0;
        end else if (wr_reload) begin
            reload_q <= wdata_cnt;
            count_q  <= wdata_cnt;
        end else if (tick) begin
            count_q  <= at_zero ? reload_q : (count_q - CNT_W'(1));
        end
    end

    // A wrap and an acknowledge on the same edge leave the flag set: no event is lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (wrap_evt && periodic_w) begin
            flag_q <= 1'b1;
        end else if (wr_ack) begin
            flag_q <= 1'b0;
        end
    end

    assign reload_o = reload_q;
    assign count_o  = count_q;
    assign ctrl_o   = ctrl_q;
    assign irq_o    = flag_q;

    // R4: a reload write lands in the count on the following cycle
    a_r4_reload_copies: assert property (@(posedge clk) disable iff (rst)
        wr_reload |=> (count_q == $past(wdata_cnt)));

    // R5: a tick on a nonzero count steps it down by exactly one
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_reload && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // R6: the flag only ever rises out of periodic mode
    a_r6_flag_only_periodic: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(periodic_w));

    // R7: an acknowledge with no coinciding tick leaves the flag low
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !tick) |=> !flag_q);

    // R10: a disabled timer keeps its count unless software reloads it
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !wr_reload) |=> $stable(count_q));

endmodule

// File: rtl/dual_timer_top.sv
module dual_timer_top
    import dtmr_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int CNT_W    = 16,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        bus_resp,
    output logic              irq
);

    localparam int BANK_IW = ADDR_W - BANK_SH;

    bus_rsp_e             rsp;
    logic [BANK_IW-1:0]   bank;
    slot_e                slot;
    logic [N_TIMERS-1:0]  wr_reload;
    logic [N_TIMERS-1:0]  wr_ctrl;
    logic [N_TIMERS-1:0]  wr_ack;
    logic [N_TIMERS-1:0]  ch_irq;
    logic [CNT_W-1:0]     ch_reload [N_TIMERS];
    logic [CNT_W-1:0]     ch_count  [N_TIMERS];
    tmr_ctrl_t            ch_ctrl   [N_TIMERS];
    tmr_ctrl_t            wctrl;
    logic                 unused_hi_bits;

    dtmr_decode #(
        .N_TIMERS (N_TIMERS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .rsp       (rsp),
        .bank      (bank),
        .slot      (slot),
        .wr_reload (wr_reload),
        .wr_ctrl   (wr_ctrl),
        .wr_ack    (wr_ack)
    );

    assign wctrl          = '{enable: bus_wdata[7], periodic: bus_wdata[6],
                              psc: psc_code_e'(bus_wdata[3:2])};
    assign unused_hi_bits = ^bus_wdata[31:CNT_W];

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        dtmr_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk        (clk),
            .rst        (rst),
            .wr_reload  (wr_reload[g]),
            .wr_ctrl    (wr_ctrl[g]),
            .wr_ack     (wr_ack[g]),
            .wdata_cnt  (bus_wdata[CNT_W-1:0]),
            .wdata_ctrl (wctrl),
            .reload_o   (ch_reload[g]),
            .count_o    (ch_count[g]),
            .ctrl_o     (ch_ctrl[g]),
            .irq_o      (ch_irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && rsp == RSP_OK) begin
            for (int i = 0; i < N_TIMERS; i++) begin
                if (bank == BANK_IW'(i)) begin
                    case (slot)
                        SLOT_RELOAD: bus_rdata = 32'(ch_reload[i]);
                        SLOT_COUNT:  bus_rdata = 32'(ch_count[i]);
                        SLOT_CTRL:   bus_rdata = ctrl_to_word(ch_ctrl[i]);
                        default:     bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign bus_resp = rsp;
    assign irq      = |ch_irq;

    // R11: a misaligned access strobes no register in any bank
    a_r11_misaligned_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_resp == 2'b01) |-> ((wr_reload | wr_ctrl | wr_ack) == '0));

    // R12: an unmapped access strobes nothing and returns zero data
    a_r12_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_resp == 2'b10) |-> (((wr_reload | wr_ctrl | wr_ack) == '0) && bus_rdata == '0));

    // R2: one access touches at most one register
    a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_reload, wr_ctrl, wr_ack}));

endmodule

// File: tb/dual_timer_top_test.sv
module dual_timer_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  bus_resp;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_timer_top uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_resp  (bus_resp),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after the write lands.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output logic [1:0] r);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #1 r = bus_resp;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // Combinational read of the state present now; consumes no clock.
    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [1:0] r);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata; r = bus_resp;
        bus_sel = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wq(input logic [7:0] a, input logic [31:0] d);
        logic [1:0] r;
        wr(a, d, r);
    endtask

    function automatic logic [31:0] nop(input logic [31:0] x);
        return x;
    endfunction

    task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d; logic [1:0] r;
        rd(a, d, r);
        chk(tag, d, exp);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [1:0] r;
        for (int b = 0; b < 2; b++) begin
            for (int o = 0; o < 4; o++) begin
                rd(8'(b * 32 + o * 4), d, r);
                chk("R1 reset register value", d, 32'h0);
                chk("R1 reset response", 32'(r), 32'h0);
            end
        end
        chk("R1 reset irq", 32'(irq), 32'h0);
    endtask

    task automatic t_regmap();
        logic [1:0] r;
        wq(8'h00, 32'h1234_ABCD);
        rchk("R2 reload keeps low 16 bits", 8'h00, 32'h0000_ABCD);
        rchk("R4 count copied from reload", 8'h04, 32'h0000_ABCD);
        rchk("R2 bank1 untouched by bank0 write", 8'h20, 32'h0);
        wr(8'h04, 32'h0000_5555, r);
        chk("R2 count write response OK", 32'(r), 32'h0);
        rchk("R2 count write ignored", 8'h04, 32'h0000_ABCD);
        rchk("R2 acknowledge reads zero", 8'h0C, 32'h0);
    endtask

    task automatic t_ctrl_fields();
        wq(8'h08, 32'hFFFF_FF7F);
        rchk("R3 control readback, spare bits zero", 8'h08, 32'h0000_004C);
        wq(8'h08, 32'h0000_00B4);
        rchk("R3 control readback enable+code1", 8'h08, 32'h0000_0084);
        wq(8'h08, 32'h0);
        rchk("R3 control cleared", 8'h08, 32'h0);
    endtask

    task automatic t_errors();
        logic [31:0] d; logic [1:0] r;
        wr(8'h02, 32'h0000_7777, r);
        chk("R11 misaligned write response", 32'(r), 32'h1);
        rchk("R11 misaligned write ignored", 8'h00, 32'h0000_ABCD);
        rd(8'h05, d, r);
        chk("R11 misaligned read response", 32'(r), 32'h1);
        chk("R11 misaligned read data", d, 32'h0);
        wr(8'h10, 32'h0000_00C0, r);
        chk("R12 hole write response", 32'(r), 32'h2);
        wr(8'h40, 32'h0000_1111, r);
        chk("R12 absent bank write response", 32'(r), 32'h2);
        rd(8'h30, d, r);
        chk("R12 hole read response", 32'(r), 32'h2);
        chk("R12 hole read data", d, 32'h0);
        rd(8'hE0, d, r);
        chk("R12 absent bank read response", 32'(r), 32'h2);
        rchk("R12 no state changed bank0", 8'h08, 32'h0);
        rchk("R12 no state changed bank1", 8'h20, 32'h0);
    endtask

    task automatic t_free_run();
        wq(8'h08, 32'h0);
        wq(8'h00, 32'd3);
        wq(8'h08, 32'h80);
        rchk("R5 start value", 8'h04, 32'd3);
        step(1); rchk("R5 decrement 1", 8'h04, 32'd2);
        step(1); rchk("R5 decrement 2", 8'h04, 32'd1);
        step(1); rchk("R5 reaches zero", 8'h04, 32'd0);
        step(1); rchk("R5 reload on zero tick", 8'h04, 32'd3);
        chk("R5 no interrupt in free-running", 32'(irq), 32'h0);
        wq(8'h08, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] d0; logic [1:0] r;
        rd(8'h04, d0, r);
        step(6);
        rchk("R10 disabled count holds", 8'h04, d0);
    endtask

    task automatic t_periodic();
        wq(8'h08, 32'h0);
        wq(8'h00, 32'd2);
        wq(8'h08, 32'hC0);
        rchk("R6 start value", 8'h04, 32'd2);
        step(1); rchk("R6 decrement", 8'h04, 32'd1);
        step(1); rchk("R6 zero", 8'h04, 32'd0);
        chk("R6 no flag before wrap tick", 32'(irq), 32'h0);
        step(1); rchk("R6 reload on wrap", 8'h04, 32'd2);
        chk("R6 flag set on wrap", 32'(irq), 32'h1);
        wq(8'h0C, 32'hDEAD_BEEF);
        chk("R7 acknowledge clears flag", 32'(irq), 32'h0);
        wq(8'h08, 32'h0);
    endtask

    task automatic t_prescale();
        wq(8'h28, 32'h0); wq(8'h20, 32'd5); wq(8'h28, 32'h84);
        step(15); rchk("R8 div16 no decrement before 16 clocks", 8'h24, 32'd5);
        step(1);  rchk("R8 div16 decrement at 16 clocks", 8'h24, 32'd4);
        wq(8'h28, 32'h0); wq(8'h20, 32'd5); wq(8'h28, 32'h88);
        step(255); rchk("R8 div256 no decrement before 256 clocks", 8'h24, 32'd5);
        step(1);   rchk("R8 div256 decrement at 256 clocks", 8'h24, 32'd4);
        wq(8'h28, 32'h0); wq(8'h20, 32'd5); wq(8'h28, 32'h8C);
        rchk("R8 code3 start", 8'h24, 32'd5);
        step(1); rchk("R8 code3 divides by 1", 8'h24, 32'd4);
        wq(8'h28, 32'h0);
    endtask

    task automatic t_restart();
        wq(8'h28, 32'h0); wq(8'h20, 32'd10); wq(8'h28, 32'h84);
        step(10);
        wq(8'h28, 32'h84);
        step(15); rchk("R9 control write restarts prescaler", 8'h24, 32'd10);
        step(1);  rchk("R9 decrement a full period after restart", 8'h24, 32'd9);
        wq(8'h28, 32'h0);
    endtask

    task automatic t_reload_running();
        wq(8'h08, 32'h80);
        wq(8'h00, 32'd100);
        rchk("R4 reload while running lands at once", 8'h04, 32'd100);
        step(1); rchk("R4 counting resumes from new value", 8'h04, 32'd99);
        wq(8'h08, 32'h0);
    endtask

    task automatic t_irq_or();
        wq(8'h28, 32'h0); wq(8'h20, 32'd0); wq(8'h28, 32'hC0);
        step(1);
        chk("R6 bank1 wrap raises irq", 32'(irq), 32'h1);
        wq(8'h28, 32'h0);
        chk("R7 flag survives disable", 32'(irq), 32'h1);
        wq(8'h0C, 32'h0);
        chk("R7 other bank acknowledge leaves irq", 32'(irq), 32'h1);
        wq(8'h2C, 32'h0);
        chk("R7 own acknowledge drops irq", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_ctrl_fields();
        t_errors();
        t_free_run();
        t_hold();
        t_periodic();
        t_prescale();
        t_restart();
        t_reload_running();
        t_irq_or();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule